// File: doc/BRIEF.md
# Control-Period Failover Arbiter

Once per control period this block decides whether the plant receives the command of the complex (monitored) controller or that of the trusted safety controller. At the start of each period it polls a mailbox for the complex controller's command and arms a watchdog. Polling is the only way a command can arrive, so the monitored side has no interrupt path into the arbiter. A failure hands control to the safety controller. A failure is a watchdog expiry, an anomaly verdict from the timing checker, or an out-of-envelope flag on the captured command. On that failover the block sends a single-cycle reset request to the monitored core so that the core can be reloaded.

How control returns depends on a policy strap. In latched mode the safety controller keeps control until an operator clear. This stops a compromised core from toggling control back and forth. In return-allowed mode a recovery-complete signal arms one full trial period. If the complex controller delivers a valid, in-time command with no fault during that trial, it regains the plant at the next period. The trial period itself still forwards the safety command.

The period length and the watchdog window are parameters, counted in clock cycles. The defaults give a 10 ms period at 125 MHz.

Top module: `failover_arbiter`

## Requirements
- R1: After reset, `cmdValid` and `coreResetReq` are low and `onSafety` is low, so the complex controller is the active source.
- R2: Exactly one command is forwarded per period. `cmdValid` is high for one cycle, in the first cycle of the following period.
- R3: `mbxRd` is high from the first cycle of each period until a command is taken or the watchdog window of `WDOG_CYCLES` cycles ends. A command is taken in a cycle where `mbxRd` and `mbxValid` are both high. A command offered in window cycle `WDOG_CYCLES-1` is taken. One offered later stays in the mailbox and is taken in the first cycle of the next period.
- R4: While the complex controller is active, a command taken in time with no anomaly and no envelope violation is forwarded unchanged.
- R5: While the complex controller is active, a watchdog expiry with no command taken causes failover, and the safety command is forwarded for that period.
- R6: While the complex controller is active, an `anomaly` pulse in any cycle of the period causes failover, and the safety command is forwarded for that period.
- R7: While the complex controller is active, `envViolation` high in the last cycle of the period causes failover, and the safety command is forwarded.
- R8: Each failover produces exactly one single-cycle `coreResetReq` pulse. Anomalies and timeouts while on safety control outside a trial produce none.
- R9: With `holdUntilClear` high, a failover latches safety control. `recoveryDone` has no effect. After an `opClear` pulse, the complex controller is forwarded again from the next period.
- R10: With `holdUntilClear` low, `recoveryDone` arms a trial over the whole next period, during which the safety command is forwarded. If the trial passes, the complex controller is active from the following period.
- R11: A trial period with a timeout, an anomaly or an envelope violation fails. It issues one `coreResetReq` pulse and returns to waiting for recovery.
- R12: `onSafety` is high whenever the safety controller is the selected source, and control returns to the complex controller only at a period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| holdUntilClear | input | 1 | Policy: 1 latches safety control until opClear, 0 allows a return after a recovery trial |
| mbxValid | input | 1 | Mailbox holds a command from the complex controller |
| mbxCmd | input | DATA_W | Command held in the mailbox |
| mbxRd | output | 1 | Poll strobe; pops the mailbox when mbxValid is high |
| safeCmd | input | DATA_W | Command from the safety controller |
| anomaly | input | 1 | Timing-checker anomaly verdict pulse |
| envViolation | input | 1 | Captured complex command lies outside the safety envelope |
| recoveryDone | input | 1 | Monitored core has been reloaded (pulse) |
| opClear | input | 1 | Operator clear of a latched takeover (pulse) |
| cmdOut | output | DATA_W | Command forwarded to the plant |
| cmdValid | output | 1 | One-cycle strobe marking cmdOut for the period |
| onSafety | output | 1 | Safety controller is the active source |
| coreResetReq | output | 1 | One-cycle reset request to the monitored core |

## Verification
The bench aims at the edge of the watchdog window. A command offered in the last window cycle must be forwarded, and one offered a cycle later must cause a timeout; an off-by-one watchdog gets one of these wrong and forwards a stale or missing command. It also injects anomalies while already on safety control, where a design that issues a second reset pulse or restarts the trial would be caught. Trials that fail on each kind of fault, operator clears under the latched policy, and `recoveryDone` arriving while latched are all covered. A design that returned mid-period, skipped the trial or let recovery release a latch would forward the wrong command or report the wrong source.

// File: rtl/fo_pkg.sv
package fo_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE  = 3'd0,
    ST_HOLD    = 3'd1,
    ST_ARMED   = 3'd2,
    ST_TRIAL   = 3'd3,
    ST_LATCHED = 3'd4,
    ST_RESUME  = 3'd5
  } foState_e;

  // control -> datapath
  typedef struct packed {
    logic forward;
    logic selComplex;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic periodEnd;
    logic cmdHeld;
    logic wdExpire;
  } dpStatus_t;

endpackage

// File: rtl/fo_datapath.sv
module fo_datapath
  import fo_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int PERIOD_CYCLES = 1250000,
  parameter int WDOG_CYCLES   = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mbxValid,
  input  logic [DATA_W-1:0] mbxCmd,
  output logic              mbxRd,
  input  logic [DATA_W-1:0] safeCmd,
  input  ctlStrobe_t        strobe,
  output dpStatus_t         status,
  output logic [DATA_W-1:0] cmdOut,
  output logic              cmdValid
);

  localparam int PH_W = $clog2(PERIOD_CYCLES);
  localparam int WD_W = $clog2(WDOG_CYCLES + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD_CYCLES - 1);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(WDOG_CYCLES - 1);

  logic [PH_W-1:0]   phase;
  logic [WD_W-1:0]   wdCnt;
  logic              wdLive;
  logic              cmdHeld;
  logic [DATA_W-1:0] heldCmd;
  logic              periodEnd;
  logic              polling;
  logic              take;
  logic              wdExpire;

  assign periodEnd = (phase == PH_LAST);
  assign polling   = wdLive && !cmdHeld;
  assign take      = polling && mbxValid;
  assign wdExpire  = polling && !mbxValid && (wdCnt == '0);
  assign mbxRd     = polling;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (periodEnd) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  // watchdog and capture of the polled command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdCnt   <= WD_LAST;
      wdLive  <= 1'b1;
      cmdHeld <= 1'b0;
      heldCmd <= '0;
    end else if (periodEnd) begin
      wdCnt   <= WD_LAST;
      wdLive  <= 1'b1;
      cmdHeld <= 1'b0;
    end else if (take) begin
      cmdHeld <= 1'b1;
      heldCmd <= mbxCmd;
    end else if (wdExpire) begin
      wdLive  <= 1'b0;
    end else if (polling) begin
      wdCnt   <= wdCnt - 1'b1;
    end
  end

  // one forwarded command per period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdOut   <= '0;
      cmdValid <= 1'b0;
    end else begin
      cmdValid <= strobe.forward;
      if (strobe.forward) begin
        cmdOut <= strobe.selComplex ? heldCmd : safeCmd;
      end
    end
  end

  always_comb begin
    status.periodEnd = periodEnd;
    status.cmdHeld   = cmdHeld;
    status.wdExpire  = wdExpire;
  end

endmodule

// File: rtl/fo_control.sv
module fo_control
  import fo_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       holdUntilClear,
  input  logic       anomaly,
  input  logic       envViolation,
  input  logic       recoveryDone,
  input  logic       opClear,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       onSafety,
  output logic       coreResetReq
);

  foState_e state, stateNext;
  logic     judged;
  logic     failNow;
  foState_e safeState;

  always_comb begin
    judged    = (state == ST_ACTIVE) || (state == ST_TRIAL);
    failNow   = judged && (anomaly || status.wdExpire ||
                (status.periodEnd && (!status.cmdHeld || envViolation)));
    safeState = holdUntilClear ? ST_LATCHED : ST_HOLD;

    stateNext = state;
    unique case (state)
      ST_ACTIVE:  if (failNow) stateNext = safeState;
      ST_TRIAL: begin
        if (failNow)               stateNext = safeState;
        else if (status.periodEnd) stateNext = ST_ACTIVE;
      end
      ST_HOLD:    if (recoveryDone)     stateNext = ST_ARMED;
      ST_ARMED:   if (status.periodEnd) stateNext = ST_TRIAL;
      ST_LATCHED: if (opClear)          stateNext = ST_RESUME;
      ST_RESUME:  if (status.periodEnd) stateNext = ST_ACTIVE;
      default:    stateNext = safeState;
    endcase

    strobe.forward    = status.periodEnd;
    strobe.selComplex = (state == ST_ACTIVE) && status.cmdHeld && !failNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_ACTIVE;
      coreResetReq <= 1'b0;
    end else begin
      state        <= stateNext;
      coreResetReq <= failNow;
    end
  end

  assign onSafety = (state != ST_ACTIVE);

endmodule

// File: rtl/failover_arbiter.sv
module failover_arbiter
  import fo_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int PERIOD_CYCLES = 1250000,
  parameter int WDOG_CYCLES   = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              holdUntilClear,
  input  logic              mbxValid,
  input  logic [DATA_W-1:0] mbxCmd,
  output logic              mbxRd,
  input  logic [DATA_W-1:0] safeCmd,
  input  logic              anomaly,
  input  logic              envViolation,
  input  logic              recoveryDone,
  input  logic              opClear,
  output logic [DATA_W-1:0] cmdOut,
  output logic              cmdValid,
  output logic              onSafety,
  output logic              coreResetReq
);

  ctlStrobe_t strobe;
  dpStatus_t  status;

  fo_datapath #(
    .DATA_W(DATA_W),
    .PERIOD_CYCLES(PERIOD_CYCLES),
    .WDOG_CYCLES(WDOG_CYCLES)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .mbxValid(mbxValid),
    .mbxCmd(mbxCmd),
    .mbxRd(mbxRd),
    .safeCmd(safeCmd),
    .strobe(strobe),
    .status(status),
    .cmdOut(cmdOut),
    .cmdValid(cmdValid)
  );

  fo_control u_ctl (
    .clk(clk),
    .rstN(rstN),
    .holdUntilClear(holdUntilClear),
    .anomaly(anomaly),
    .envViolation(envViolation),
    .recoveryDone(recoveryDone),
    .opClear(opClear),
    .status(status),
    .strobe(strobe),
    .onSafety(onSafety),
    .coreResetReq(coreResetReq)
  );

endmodule

// File: rtl/fo_checker.sv
module fo_checker #(
  parameter int DATA_W        = 16,
  parameter int PERIOD_CYCLES = 1250000,
  parameter int WDOG_CYCLES   = 1000000
) (
  input logic              clk,
  input logic              rstN,
  input logic              mbxRd,
  input logic [DATA_W-1:0] safeCmd,
  input logic [DATA_W-1:0] cmdOut,
  input logic              cmdValid,
  input logic              onSafety,
  input logic              coreResetReq
);

  localparam int PH_W = $clog2(PERIOD_CYCLES);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD_CYCLES - 1);
  localparam logic [PH_W-1:0] WIN     = PH_W'(WDOG_CYCLES);

  logic [PH_W-1:0] chkPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    chkPhase <= '0;
    else if (chkPhase == PH_LAST) chkPhase <= '0;
    else                          chkPhase <= chkPhase + 1'b1;
  end

  AST_ONE_FWD: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);                                            // R2
  AST_FWD_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (chkPhase == '0));                                     // R2
  AST_POLL_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    mbxRd |-> (chkPhase < WIN));                                        // R3
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    coreResetReq |=> !coreResetReq);                                    // R8
  AST_RST_ON_SWITCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(onSafety) |-> coreResetReq);                                  // R8
  AST_RST_SAFE: assert property (@(posedge clk) disable iff (!rstN)
    coreResetReq |-> onSafety);                                         // R8
  AST_SAFE_FWD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && $past(onSafety)) |-> (cmdOut == $past(safeCmd)));      // R12
  AST_RETURN_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(onSafety) |-> cmdValid);                                      // R12

endmodule

bind failover_arbiter fo_checker #(
  .DATA_W(DATA_W),
  .PERIOD_CYCLES(PERIOD_CYCLES),
  .WDOG_CYCLES(WDOG_CYCLES)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .mbxRd(mbxRd),
  .safeCmd(safeCmd),
  .cmdOut(cmdOut),
  .cmdValid(cmdValid),
  .onSafety(onSafety),
  .coreResetReq(coreResetReq)
);

// File: tb/failover_arbiter_tb.sv
module failover_arbiter_tb;

  localparam int DW = 16;
  localparam int P  = 40;
  localparam int W  = 24;

  localparam int M_ACTIVE  = 0;
  localparam int M_HOLD    = 1;
  localparam int M_TRIAL   = 2;
  localparam int M_LATCHED = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          holdUntilClear = 1'b0;
  logic          mbxValid = 1'b0;
  logic [DW-1:0] mbxCmd = '0;
  logic          mbxRd;
  logic [DW-1:0] safeCmd = '0;
  logic          anomaly = 1'b0;
  logic          envViolation = 1'b0;
  logic          recoveryDone = 1'b0;
  logic          opClear = 1'b0;
  logic [DW-1:0] cmdOut;
  logic          cmdValid;
  logic          onSafety;
  logic          coreResetReq;

  always #4 clk = ~clk;

  failover_arbiter #(.DATA_W(DW), .PERIOD_CYCLES(P), .WDOG_CYCLES(W)) u_dut (
    .clk(clk), .rstN(rstN), .holdUntilClear(holdUntilClear),
    .mbxValid(mbxValid), .mbxCmd(mbxCmd), .mbxRd(mbxRd), .safeCmd(safeCmd),
    .anomaly(anomaly), .envViolation(envViolation), .recoveryDone(recoveryDone),
    .opClear(opClear), .cmdOut(cmdOut), .cmdValid(cmdValid),
    .onSafety(onSafety), .coreResetReq(coreResetReq)
  );

  int nChecks = 0;
  int nFails  = 0;

  // bench reference state, period granularity
  int            mSt = M_ACTIVE;
  bit            pend = 1'b0;
  logic [DW-1:0] pendData = '0;
  bit            full = 1'b0;
  logic [DW-1:0] fullData = '0;
  bit            lastFire = 1'b0;
  bit            havePrev = 1'b0;
  logic [DW-1:0] prevCmd = '0;
  int            prevRst = 0;
  bit            prevSafe = 1'b0;
  string         prevTag = "R4";
  int            rstSeen = 0;
  int            validSeen = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int nextState(input int st, input bit fail, input bit recov,
                                   input bit clr, input bit latch);
    if (fail) return latch ? M_LATCHED : M_HOLD;
    case (st)
      M_ACTIVE:  return M_ACTIVE;
      M_TRIAL:   return M_ACTIVE;
      M_HOLD:    return recov ? M_TRIAL : M_HOLD;
      default:   return clr ? M_ACTIVE : M_LATCHED;
    endcase
  endfunction

  task automatic runPeriod(input bit postIn, input int k, input logic [DW-1:0] data,
                           input bit ano, input int anoPh, input bit env,
                           input bit recovIn, input bit clrIn);
    bit            post, recov, clr, inTime, judged, fail, fwdC;
    logic [DW-1:0] useData, safeNow;
    int            stNext;
    string         tag;
    post    = postIn && !pend;
    recov   = recovIn && (mSt == M_HOLD || mSt == M_LATCHED);
    clr     = clrIn && (mSt == M_LATCHED);
    inTime  = pend || (post && k < W);
    useData = pend ? pendData : data;
    judged  = (mSt == M_ACTIVE) || (mSt == M_TRIAL);
    fail    = judged && (ano || !inTime || env);
    fwdC    = (mSt == M_ACTIVE) && !fail;
    safeNow = DW'($urandom);
    stNext  = nextState(mSt, fail, recov && mSt == M_HOLD, clr, holdUntilClear);
    if (fail)                 tag = (mSt == M_TRIAL) ? "R11" : (ano ? "R6" : (!inTime ? "R5" : "R7"));
    else if (fwdC)            tag = "R4";
    else if (mSt == M_LATCHED) tag = "R9";
    else                      tag = "R10";

    for (int ph = 0; ph < P; ph++) begin
      @(negedge clk);
      rstSeen   += int'(coreResetReq);
      validSeen += int'(cmdValid);
      if (ph == 0) begin
        if (havePrev) begin
          check(cmdValid == 1'b1, "R2", "strobe at period start", cmdValid, 1);
          check(validSeen == 1, "R2", "strobes per period", validSeen, 1);
          check(cmdOut == prevCmd, prevTag, "forwarded command", cmdOut, prevCmd);
          check(rstSeen == prevRst, "R8", "reset pulses", rstSeen, prevRst);
          check(onSafety == prevSafe, "R12", "source status", onSafety, prevSafe);
        end
        rstSeen = 0;
        validSeen = 0;
      end
      if (lastFire) full = 1'b0;
      if (post && ph == k) begin
        full = 1'b1;
        fullData = data;
      end
      mbxValid     = full;
      mbxCmd       = fullData;
      anomaly      = ano && (ph == anoPh);
      recoveryDone = recov && (ph == 5);
      opClear      = clr && (ph == 5);
      envViolation = env;
      if (ph == 0) safeCmd = safeNow;
      #1;
      lastFire = mbxRd && full;
      if (ph == 0) check(mbxRd == 1'b1, "R3", "poll at period start", mbxRd, 1);
      if (ph == W) check(mbxRd == 1'b0, "R3", "poll after window", mbxRd, 0);
    end

    havePrev = 1'b1;
    prevCmd  = fwdC ? useData : safeNow;
    prevRst  = fail ? 1 : 0;
    prevSafe = (stNext != M_ACTIVE);
    prevTag  = tag;
    mSt      = stNext;
    if (pend) pend = 1'b0;
    else if (post && k >= W) begin
      pend = 1'b1;
      pendData = data;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C11));
    repeat (3) @(negedge clk);
    check(cmdValid == 1'b0, "R1", "cmdValid in reset", cmdValid, 0);
    check(coreResetReq == 1'b0, "R1", "reset request in reset", coreResetReq, 0);
    check(onSafety == 1'b0, "R1", "source in reset", onSafety, 0);
    @(posedge clk);
    #1 rstN = 1'b1;

    // return-allowed policy, directed corners
    runPeriod(1, 3,     16'h1111, 0, 0, 0, 0, 0);   // R4
    runPeriod(1, W-1,   16'h2222, 0, 0, 0, 0, 0);   // R3 last window cycle
    runPeriod(1, 0,     16'h3333, 0, 0, 0, 0, 0);
    runPeriod(1, W,     16'h4444, 0, 0, 0, 0, 0);   // R5 one cycle late
    runPeriod(0, 0,     16'h0,    1, 9, 0, 0, 0);   // stale taken, anomaly ignored (R8)
    runPeriod(0, 0,     16'h0,    0, 0, 0, 1, 0);   // recovery
    runPeriod(1, 2,     16'h5555, 0, 0, 0, 0, 0);   // R10 trial passes
    runPeriod(1, 2,     16'h6666, 0, 0, 0, 0, 0);
    runPeriod(1, 2,     16'h7777, 1, 7, 0, 0, 0);   // R6
    runPeriod(0, 0,     16'h0,    0, 0, 0, 1, 0);
    runPeriod(1, 4,     16'h8888, 0, 0, 1, 0, 0);   // R11 trial envelope fail
    runPeriod(0, 0,     16'h0,    0, 0, 0, 1, 0);
    runPeriod(1, 4,     16'h9999, 0, 0, 0, 0, 0);
    runPeriod(1, 4,     16'hAAAA, 0, 0, 1, 0, 0);   // R7
    runPeriod(0, 0,     16'h0,    0, 0, 0, 1, 0);
    runPeriod(1, 1,     16'hBBBB, 0, 0, 0, 0, 0);
    // latched policy
    holdUntilClear = 1'b1;
    runPeriod(1, 1,     16'hCCCC, 0, 0, 0, 0, 0);
    runPeriod(1, 1,     16'hDDDD, 1, 0, 0, 0, 0);   // R9 latch
    runPeriod(1, 1,     16'hEEEE, 0, 0, 0, 1, 0);   // R9 recovery ignored
    runPeriod(1, 1,     16'hF0F0, 1, 3, 0, 0, 0);
    runPeriod(1, 1,     16'h0F0F, 0, 0, 0, 0, 1);   // R9 operator clear
    runPeriod(1, 1,     16'h1234, 0, 0, 0, 0, 0);

    for (int i = 0; i < 240; i++) begin
      holdUntilClear = ((i / 60) % 2) == 1;
      runPeriod($urandom_range(0, 99) < 85, $urandom_range(0, W + 3), DW'($urandom),
                $urandom_range(0, 99) < 8, $urandom_range(0, P - 1),
                $urandom_range(0, 99) < 6, $urandom_range(0, 99) < 50,
                $urandom_range(0, 99) < 35);
    end
    runPeriod(0, 0, 16'h0, 0, 0, 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule